// File: doc/BRIEF.md
# GPIO Pad Group Controller

This block manages a group of general-purpose pads arranged in banks of up to 32 pads each. Every pad owns two 32-bit configuration words behind a byte-addressed register port. The first word drives the pad output, reports the synchronised pad input, selects input inversion and chooses how input activity is turned into an event. The second word is plain storage that reads back whatever was written.

Events from the pads of one bank land in that bank's status register, whose bits stay set until software writes ones to them. A per-bank enable register picks which status bits may reach the single interrupt output. A read-only pointer register tells software where the pad configuration array starts, so the array position is a build-time choice.

Pad inputs pass through a two-flop synchroniser before anything else sees them. Reads return their data one cycle after the read strobe, together with a valid flag.

Top module: `padgrp_ctrl`

## Requirements
- R1: The word at byte address 0x00C is read-only and returns the byte offset of the pad configuration array (parameter PAD_BASE, default 0x400). Writes to it have no effect.
- R2: Pad p's first word is at PAD_BASE + 16·p and its second word is at PAD_BASE + 16·p + 4. The second word stores all 32 bits and reads them back. Offsets +8 and +12 inside a pad slot read as zero.
- R3: In the first word, bit 0 drives pad_out[p]. Bit 1 reads pad_in[p] after a two-flop synchroniser and ignores writes. Bits 23, 26:25 and 31:30 store and read back what was written. All other bits read 0.
- R4: Bit 23 of the first word inverts the synchronised input before event detection. The sense signal is input XOR bit 23.
- R5: With event mode 00 (bits 26:25), the pad's status bit is set on every cycle in which the sense signal is high.
- R6: With event mode 01, the status bit is set only when the sense signal goes from 0 to 1.
- R7: With event mode 11, the status bit is set on every change of the sense signal, in either direction.
- R8: Event mode 10 never sets the status bit.
- R9: The status word of bank n is at 0x100 + 4·n, with bit i belonging to pad n·PADS_PER_BANK + i. Writing a one clears that bit and writing a zero leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: The enable word of bank n is at 0x120 + 4·n and is read/write. irq is high exactly when some bank has a bit set in both its status and its enable word. irq follows register changes without an extra cycle of delay.
- R11: After reset, all configuration words, status words and enable words read zero, pad_out is zero and irq is low.
- R12: A read strobe samples the addressed word at the clock edge. rdata holds that word and rvalid is high for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| pad_in | input | NUM_BANKS·PADS_PER_BANK | Asynchronous pad inputs |
| pad_out | output | NUM_BANKS·PADS_PER_BANK | Pad output levels |
| irq | output | 1 | Interrupt request |

## Verification
A wrong edge-history flop or a wrong inversion bit shows up as a missing or extra status bit in a status read, three clock edges after the pad input changes. The same fault reaches irq in that same cycle if the bit is enabled. A broken clear priority appears at the first status read after a clear of a pad that is still active in level mode. A wrong address decode is caught by the next read, either as a word landing in the wrong pad or bank slot, or as a nonzero value read from a reserved offset.

// File: rtl/padgrp_pkg.sv
`timescale 1ns/1ps
package padgrp_pkg;
   localparam int DATA_W      = 32;
   localparam int BASEPTR_OFS = 'h00C;
   localparam int STS_OFS     = 'h100;
   localparam int ENA_OFS     = 'h120;
   localparam int PAD_STRIDE  = 16;
   localparam int DW1_OFS     = 4;
   localparam int TX_BIT      = 0;
   localparam int RX_BIT      = 1;
   localparam int INV_BIT     = 23;
   localparam int MODE_LSB    = 25;
   localparam int RCFG_LSB    = 30;

   typedef enum logic [1:0] {
      EV_LEVEL = 2'b00,
      EV_RISE  = 2'b01,
      EV_NONE  = 2'b10,
      EV_BOTH  = 2'b11
   } evmode_e;
endpackage

// File: rtl/padgrp_sync.sv
`timescale 1ns/1ps
module padgrp_sync #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q, stab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         stab_q <= '0;
      end else begin
         meta_q <= d_i;
         stab_q <= meta_q;
      end
   end

   assign q_o = stab_q;

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= 2'd0;
      else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
   end

   // R3
   sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/padgrp_pad.sv
`timescale 1ns/1ps
module padgrp_pad
   import padgrp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_dw0,
   input  logic              wr_dw1,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rx_i,
   output logic [DATA_W-1:0] dw0_o,
   output logic [DATA_W-1:0] dw1_o,
   output logic              tx_o,
   output logic              evt_o
);
   logic              tx_q, inv_q, prev_q;
   evmode_e           mode_q;
   logic [1:0]        rcfg_q;
   logic [DATA_W-1:0] dw1_q;
   logic              sense;

   assign sense = rx_i ^ inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= 1'b0;
         inv_q  <= 1'b0;
         mode_q <= EV_LEVEL;
         rcfg_q <= 2'b00;
         dw1_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         if (wr_dw0) begin
            tx_q   <= wdata[TX_BIT];
            inv_q  <= wdata[INV_BIT];
            mode_q <= evmode_e'(wdata[MODE_LSB +: 2]);
            rcfg_q <= wdata[RCFG_LSB +: 2];
         end
         if (wr_dw1) dw1_q <= wdata;
         prev_q <= sense;
      end
   end

   always_comb begin
      unique case (mode_q)
         EV_LEVEL: evt_o = sense;
         EV_RISE:  evt_o = sense & ~prev_q;
         EV_BOTH:  evt_o = sense ^ prev_q;
         default:  evt_o = 1'b0;
      endcase
   end

   always_comb begin
      dw0_o                   = '0;
      dw0_o[TX_BIT]           = tx_q;
      dw0_o[RX_BIT]           = rx_i;
      dw0_o[INV_BIT]          = inv_q;
      dw0_o[MODE_LSB +: 2]    = mode_q;
      dw0_o[RCFG_LSB +: 2]    = rcfg_q;
   end

   assign dw1_o = dw1_q;
   assign tx_o  = tx_q;

   // R6
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == EV_RISE && evt_o) |-> (sense && !$past(sense)));
   // R8
   quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == EV_NONE) |-> !evt_o);
endmodule

// File: rtl/padgrp_bank.sv
`timescale 1ns/1ps
module padgrp_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         clr_we,
   input  logic         ena_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] sts_o,
   output logic [W-1:0] ena_o
);
   logic [W-1:0] sts_q, ena_q, clr_mask;

   assign clr_mask = clr_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         ena_q <= '0;
      end else begin
         sts_q <= (sts_q & ~clr_mask) | evt_i;
         if (ena_we) ena_q <= wdata;
      end
   end

   assign sts_o = sts_q;
   assign ena_o = ena_q;

   // R9
   sticky_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(sts_q) & ~$past(clr_mask)) & ~sts_q) == '0));
   // R9
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_i) & ~sts_q) == '0));
endmodule

// File: rtl/padgrp_ctrl.sv
`timescale 1ns/1ps
module padgrp_ctrl
   import padgrp_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int PADS_PER_BANK = 32,
   parameter int PAD_BASE      = 'h400,
   parameter int ADDR_W        = 12
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 rd_en,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    addr,
   input  logic [DATA_W-1:0]                    wdata,
   output logic [DATA_W-1:0]                    rdata,
   output logic                                 rvalid,
   input  logic [NUM_BANKS*PADS_PER_BANK-1:0]   pad_in,
   output logic [NUM_BANKS*PADS_PER_BANK-1:0]   pad_out,
   output logic                                 irq
);
   localparam int NPADS   = NUM_BANKS * PADS_PER_BANK;
   localparam int PB      = PADS_PER_BANK;
   localparam int PAD_END = PAD_BASE + NPADS * PAD_STRIDE;

   if (PB < 1 || PB > 32) begin : g_bad_pb
      $error("PADS_PER_BANK must be 1..32");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > 8) begin : g_bad_nb
      $error("NUM_BANKS must be 1..8");
   end
   if ((PAD_BASE % PAD_STRIDE) != 0 || PAD_BASE < ENA_OFS + 4 * 8) begin : g_bad_base
      $error("PAD_BASE must be 16-byte aligned and above the bank registers");
   end
   if (PAD_END > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too small for the pad array");
   end

   logic [NPADS-1:0]  rx_sync, evt_flat, hit0, hit1;
   logic [DATA_W-1:0] dw0_a [NPADS];
   logic [DATA_W-1:0] dw1_a [NPADS];
   logic [PB-1:0]     sts_a [NUM_BANKS];
   logic [PB-1:0]     ena_a [NUM_BANKS];
   logic [NUM_BANKS-1:0] hit_sts, hit_ena;
   logic              hit_base;
   logic [DATA_W-1:0] rd_mux, rdata_q;
   logic              rvalid_q;

   padgrp_sync #(.W(NPADS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_in),
      .q_o   (rx_sync)
   );

   assign hit_base = (addr == ADDR_W'(BASEPTR_OFS));

   for (genvar p = 0; p < NPADS; p++) begin : g_pad
      localparam int A0 = PAD_BASE + p * PAD_STRIDE;
      assign hit0[p] = (addr == ADDR_W'(A0));
      assign hit1[p] = (addr == ADDR_W'(A0 + DW1_OFS));

      padgrp_pad u_pad (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_dw0 (wr_en & hit0[p]),
         .wr_dw1 (wr_en & hit1[p]),
         .wdata  (wdata),
         .rx_i   (rx_sync[p]),
         .dw0_o  (dw0_a[p]),
         .dw1_o  (dw1_a[p]),
         .tx_o   (pad_out[p]),
         .evt_o  (evt_flat[p])
      );
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign hit_sts[b] = (addr == ADDR_W'(STS_OFS + 4 * b));
      assign hit_ena[b] = (addr == ADDR_W'(ENA_OFS + 4 * b));

      padgrp_bank #(.W(PB)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (evt_flat[b*PB +: PB]),
         .clr_we (wr_en & hit_sts[b]),
         .ena_we (wr_en & hit_ena[b]),
         .wdata  (wdata[PB-1:0]),
         .sts_o  (sts_a[b]),
         .ena_o  (ena_a[b])
      );
   end

   always_comb begin
      rd_mux = hit_base ? DATA_W'(PAD_BASE) : '0;
      for (int p = 0; p < NPADS; p++) begin
         if (hit0[p]) rd_mux |= dw0_a[p];
         if (hit1[p]) rd_mux |= dw1_a[p];
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit_sts[b]) rd_mux |= DATA_W'(sts_a[b]);
         if (hit_ena[b]) rd_mux |= DATA_W'(ena_a[b]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_en;
         if (rd_en) rdata_q <= rd_mux;
      end
   end

   assign rdata  = rdata_q;
   assign rvalid = rvalid_q;

   always_comb begin
      irq = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) irq |= |(sts_a[b] & ena_a[b]);
   end

   // R12
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);
endmodule

// File: tb/padgrp_ctrl_bench.sv
`timescale 1ns/1ps
module padgrp_ctrl_bench;
   localparam int NB = 2;
   localparam int PB = 32;
   localparam int NP = NB * PB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_en = 1'b0, wr_en = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          rvalid;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic          irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   padgrp_ctrl u_padgrp_ctrl (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
      .pad_in(pad_in), .pad_out(pad_out), .irq(irq)
   );

   function automatic logic [11:0] dw0(int p); return 12'('h400 + 16 * p); endfunction
   function automatic logic [11:0] dw1(int p); return 12'('h400 + 16 * p + 4); endfunction
   function automatic logic [11:0] sts(int b); return 12'('h100 + 4 * b); endfunction
   function automatic logic [11:0] ena(int b); return 12'('h120 + 4 * b); endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_exp(logic [11:0] a, logic [31:0] e, string tag);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // monitor: pops expected read data as the design returns it (R12)
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) begin
            chk("R12 unexpected rvalid", 32'(rvalid), 32'd0);
         end else begin
            chk(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 irq", 32'(irq), 32'd0);
      chk("R11 pad_out", 32'(|pad_out), 32'd0);
      chk("R12 rvalid idle", 32'(rvalid), 32'd0);
      rd_exp(dw0(5), 32'h0, "R11 dw0");
      rd_exp(dw1(63), 32'h0, "R11 dw1");
      rd_exp(sts(1), 32'h0, "R11 status");
      rd_exp(ena(0), 32'h0, "R11 enable");

      // R1 pointer register, write ignored
      wr(12'h00C, 32'hDEAD_BEEF);
      rd_exp(12'h00C, 32'h0000_0400, "R1 pointer");

      // R3 output bit and stored fields
      wr(dw0(5), 32'hC000_0001);
      @(negedge clk);
      chk("R3 pad_out[5]", 32'(pad_out[5]), 32'd1);
      rd_exp(dw0(5), 32'hC000_0001, "R3 dw0 readback");
      wr(dw0(6), 32'h0000_0002);
      rd_exp(dw0(6), 32'h0, "R3 rx bit ignores writes");
      wr(dw0(7), 32'h797F_FFFC);
      rd_exp(dw0(7), 32'h4000_0000, "R3 unused bits read zero");

      // R2 second word and layout
      wr(dw1(9), 32'hA5A5_5A5A);
      rd_exp(dw1(9), 32'hA5A5_5A5A, "R2 dw1 pad9");
      wr(dw1(63), 32'h1234_5678);
      rd_exp(dw1(63), 32'h1234_5678, "R2 dw1 last pad");
      rd_exp(12'('h400 + 16 * 9 + 8), 32'h0, "R2 reserved slot");
      rd_exp(dw0(9), 32'h0, "R2 dw0 untouched");

      // R3 rx, R5 level mode, R9 event wins over clear
      pad_in[5] = 1'b1;
      settle();
      rd_exp(dw0(5), 32'hC000_0003, "R3 rx level");
      rd_exp(sts(0), 32'h0000_0020, "R5 level sets status");
      wr(sts(0), 32'h0000_0020);
      rd_exp(sts(0), 32'h0000_0020, "R9 event wins over clear");
      pad_in[5] = 1'b0;
      settle();
      wr(sts(0), 32'h0000_0020);
      rd_exp(sts(0), 32'h0, "R9 write-one clears");

      // R6 rising edge, pad 40 = bank1 bit8
      wr(dw0(40), 32'h0200_0000);
      pad_in[40] = 1'b1;
      settle();
      rd_exp(sts(1), 32'h0000_0100, "R6 rise event");
      wr(sts(1), 32'h0000_0100);
      rd_exp(sts(1), 32'h0, "R6 no event while held high");
      pad_in[40] = 1'b0;
      settle();
      rd_exp(sts(1), 32'h0, "R6 fall ignored");

      // R4 inversion
      wr(dw0(40), 32'h0280_0000);
      settle();
      wr(sts(1), 32'h0000_0100);
      pad_in[40] = 1'b1;
      settle();
      rd_exp(sts(1), 32'h0, "R4 inverted rise of input ignored");
      pad_in[40] = 1'b0;
      settle();
      rd_exp(sts(1), 32'h0000_0100, "R4 inverted fall is event");
      wr(sts(1), 32'h0000_0100);

      // R7 both edges, pad 41 = bank1 bit9
      wr(dw0(41), 32'h0600_0000);
      pad_in[41] = 1'b1;
      settle();
      rd_exp(sts(1), 32'h0000_0200, "R7 rise event");
      wr(sts(1), 32'h0000_0200);
      rd_exp(sts(1), 32'h0, "R7 cleared");
      pad_in[41] = 1'b0;
      settle();
      rd_exp(sts(1), 32'h0000_0200, "R7 fall event");

      // R10 enable gating
      @(negedge clk);
      chk("R10 irq masked", 32'(irq), 32'd0);
      wr(ena(1), 32'h0000_0200);
      chk("R10 irq enabled", 32'(irq), 32'd1);
      rd_exp(ena(1), 32'h0000_0200, "R10 enable readback");
      wr(ena(1), 32'h0);
      chk("R10 irq after disable", 32'(irq), 32'd0);
      wr(ena(1), 32'h0000_0200);
      chk("R10 irq re-enabled", 32'(irq), 32'd1);
      wr(sts(1), 32'h0000_0200);
      chk("R10 irq after clear", 32'(irq), 32'd0);

      // R8 mode 10 silent, pad 42
      wr(dw0(42), 32'h0400_0000);
      pad_in[42] = 1'b1;
      settle();
      pad_in[42] = 1'b0;
      settle();
      rd_exp(sts(1), 32'h0, "R8 no events");

      repeat (3) @(negedge clk);
      chk("R12 all reads returned", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule